// File: doc/BRIEF.md
# ATM Cell VPI Port Filter

This block sits on the receive side of a cell-to-TDM interworking path. It serves a single TDM port. For each parsed ATM cell header it decides whether the cell belongs to that port. A per-port configuration word holds the expected path identifier and an enable for maintenance cells. The word is loaded through a write strobe and a data word, and it is always visible on a read-back bus.

A static mode input selects the header layout. In user-side (UNI) layout the path identifier is 8 bits wide. In network-side (NNI) layout it is 12 bits wide. Header fields arrive together with a valid strobe. One clock later the block presents a decision code with a decision-valid strobe. The code tells the downstream cell store to keep the cell as user data, keep it as an OAM cell, or drop it.

The decision sequencer has two states. ST_IDLE means no decision is on the outputs. ST_EMIT means a decision is on the outputs for this cycle. A header strobe moves the sequencer from ST_IDLE to ST_EMIT, or keeps it in ST_EMIT when strobes arrive back to back. A cycle without a strobe returns it from ST_EMIT to ST_IDLE.

Top module: `vpf_port_filter`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000, `dec_valid` is 0 and `dec_code` is 2'b00.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata[12:0]` into the configuration word. Bits 11:0 hold the expected path identifier and bit 12 is the OAM enable. Bits 15:13 read back as 0 whatever was written. Without `cfg_wr`, the word keeps its value.
- R3: With `nni_mode` = 0, the cell matches when `hdr_vpi[7:0]` equals configuration bits 7:0. Bits 11:8 of both the incoming field and the configured value are ignored.
- R4: With `nni_mode` = 1, the cell matches only when all 12 bits of `hdr_vpi` equal configuration bits 11:0.
- R5: A cell is an OAM cell when `hdr_vci` is 3 or 4, or when `hdr_pti` is 3'b100 or 3'b101. Every other VCI/PTI combination, including PTI 3'b110, is user data.
- R6: A matching OAM cell gives code 2'b10 (OAM kept) when the OAM enable is 1, and code 2'b00 (drop) when it is 0.
- R7: A matching non-OAM cell gives code 2'b01 (data kept). A non-matching cell gives 2'b00 whatever its type and whatever the OAM enable.
- R8: `dec_valid` is high in exactly the cycle after each cycle with `hdr_valid` high, including back-to-back strobes. `dec_code` is 2'b00 whenever `dec_valid` is low.
- R9: A decision uses the configuration word held in the strobe cycle. A write in that same cycle affects only later headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back, bits 15:13 zero |
| nni_mode | input | 1 | 0 = UNI 8-bit path id, 1 = NNI 12-bit path id |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_vpi | input | 12 | Incoming path identifier |
| hdr_vci | input | 16 | Incoming channel identifier |
| hdr_pti | input | 3 | Incoming payload type |
| dec_valid | output | 1 | Decision present this cycle |
| dec_code | output | 2 | 00 drop, 01 data, 10 OAM |

## Verification
The bench varies the upper nibble of the path identifier in UNI mode. A filter that compared all 12 bits there would drop cells that should be accepted, and the same stimulus in NNI mode catches the opposite mistake. It steps through every OAM-marking VCI and PTI value, plus the resource-management PTI 3'b110. A wrong classifier would then forward maintenance cells as data or drop valid data. Back-to-back strobes and a write in the same cycle as a strobe expose a sequencer that swallows the second decision, and a datapath that applies a new word one cycle early. Writes of all-ones data show whether the reserved bits leak into the read-back.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

    typedef enum logic [1:0] {
        DEC_DROP = 2'b00,
        DEC_DATA = 2'b01,
        DEC_OAM  = 2'b10
    } dec_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_e;

    localparam int unsigned F4_SEG_VCI  = 3;
    localparam int unsigned F4_E2E_VCI  = 4;
    localparam logic [2:0]  F5_SEG_PTI  = 3'b100;
    localparam logic [2:0]  F5_E2E_PTI  = 3'b101;

endpackage

// File: rtl/vpf_cfg_reg.sv
module vpf_cfg_reg #(
    parameter int REG_W = 16,
    parameter int VPI_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [VPI_W-1:0] exp_vpi,
    output logic             oam_en
);
    localparam int USED_W = VPI_W + 1;
    localparam int RSVD_W = REG_W - USED_W;

    logic [USED_W-1:0] word_q;
    logic              unused_rsvd;

    assign unused_rsvd = ^wdata[REG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr) begin
            word_q <= wdata[USED_W-1:0];
        end
    end

    assign rdata   = {{RSVD_W{1'b0}}, word_q};
    assign exp_vpi = word_q[VPI_W-1:0];
    assign oam_en  = word_q[VPI_W];
endmodule

// File: rtl/vpf_hdr_class.sv
module vpf_hdr_class
    import vpf_pkg::*;
#(
    parameter int VPI_W = 12,
    parameter int UNI_W = 8,
    parameter int VCI_W = 16,
    parameter int PTI_W = 3
) (
    input  logic [VPI_W-1:0] exp_vpi,
    input  logic             oam_en,
    input  logic             nni_mode,
    input  logic [VPI_W-1:0] vpi,
    input  logic [VCI_W-1:0] vci,
    input  logic [PTI_W-1:0] pti,
    output dec_e             dec
);
    localparam logic [VCI_W-1:0] VCI_A = VCI_W'(F4_SEG_VCI);
    localparam logic [VCI_W-1:0] VCI_B = VCI_W'(F4_E2E_VCI);
    localparam logic [PTI_W-1:0] PTI_A = PTI_W'(F5_SEG_PTI);
    localparam logic [PTI_W-1:0] PTI_B = PTI_W'(F5_E2E_PTI);

    logic low_eq, high_eq, vpi_hit, is_f4, is_f5, is_oam;

    // UNI uses only the low field; NNI adds the upper bits
    assign low_eq  = (vpi[UNI_W-1:0] == exp_vpi[UNI_W-1:0]);
    assign high_eq = (vpi[VPI_W-1:UNI_W] == exp_vpi[VPI_W-1:UNI_W]);
    assign vpi_hit = low_eq && (high_eq || !nni_mode);

    assign is_f4  = (vci == VCI_A) || (vci == VCI_B);
    assign is_f5  = (pti == PTI_A) || (pti == PTI_B);
    assign is_oam = is_f4 || is_f5;

    always_comb begin
        if (!vpi_hit) begin
            dec = DEC_DROP;
        end else if (is_oam) begin
            dec = oam_en ? DEC_OAM : DEC_DROP;
        end else begin
            dec = DEC_DATA;
        end
    end
endmodule

// File: rtl/vpf_route_seq.sv
module vpf_route_seq
    import vpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdr_valid,
    input  dec_e       dec_now,
    output logic       dec_valid,
    output logic [1:0] dec_code
);
    seq_e state_q, state_nx;
    dec_e dec_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = hdr_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = hdr_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dec_q   <= DEC_DROP;
        end else begin
            state_q <= state_nx;
            dec_q   <= hdr_valid ? dec_now : DEC_DROP;
        end
    end

    always_comb begin
        dec_valid = 1'b0;
        dec_code  = DEC_DROP;
        unique case (state_q)
            ST_IDLE: begin
                dec_valid = 1'b0;
                dec_code  = DEC_DROP;
            end
            ST_EMIT: begin
                dec_valid = 1'b1;
                dec_code  = dec_q;
            end
            default: begin
                dec_valid = 1'b0;
                dec_code  = DEC_DROP;
            end
        endcase
    end
endmodule

// File: rtl/vpf_port_filter.sv
module vpf_port_filter
    import vpf_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int VPI_W = 12,
    parameter int UNI_W = 8,
    parameter int VCI_W = 16,
    parameter int PTI_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             nni_mode,
    input  logic             hdr_valid,
    input  logic [VPI_W-1:0] hdr_vpi,
    input  logic [VCI_W-1:0] hdr_vci,
    input  logic [PTI_W-1:0] hdr_pti,
    output logic             dec_valid,
    output logic [1:0]       dec_code
);
    logic [VPI_W-1:0] exp_vpi;
    logic             oam_en;
    dec_e             dec_now;

    vpf_cfg_reg #(.REG_W(REG_W), .VPI_W(VPI_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .exp_vpi (exp_vpi),
        .oam_en  (oam_en)
    );

    vpf_hdr_class #(.VPI_W(VPI_W), .UNI_W(UNI_W), .VCI_W(VCI_W), .PTI_W(PTI_W)) u_cls (
        .exp_vpi  (exp_vpi),
        .oam_en   (oam_en),
        .nni_mode (nni_mode),
        .vpi      (hdr_vpi),
        .vci      (hdr_vci),
        .pti      (hdr_pti),
        .dec      (dec_now)
    );

    vpf_route_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .dec_now   (dec_now),
        .dec_valid (dec_valid),
        .dec_code  (dec_code)
    );
endmodule

// File: rtl/vpf_port_filter_chk.sv
module vpf_port_filter_chk #(
    parameter int REG_W = 16,
    parameter int VPI_W = 12,
    parameter int UNI_W = 8,
    parameter int VCI_W = 16,
    parameter int PTI_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             nni_mode,
    input logic             hdr_valid,
    input logic [VPI_W-1:0] hdr_vpi,
    input logic [VCI_W-1:0] hdr_vci,
    input logic [PTI_W-1:0] hdr_pti,
    input logic             dec_valid,
    input logic [1:0]       dec_code
);
    logic oam_cell;
    assign oam_cell = (hdr_vci == VCI_W'(3)) || (hdr_vci == VCI_W'(4)) ||
                      (hdr_pti == 3'b100) || (hdr_pti == 3'b101);

    // R8
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> dec_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !dec_valid);
    a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> dec_code == 2'b00);
    // R2
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata[VPI_W:0] == $past(cfg_wdata[VPI_W:0]));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_rdata));
    // R4, R7
    a_r4_nni_mismatch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && nni_mode && hdr_vpi != cfg_rdata[VPI_W-1:0]) |=> dec_code == 2'b00);
    // R3, R7
    a_r3_uni_mismatch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !nni_mode && hdr_vpi[UNI_W-1:0] != cfg_rdata[UNI_W-1:0]) |=> dec_code == 2'b00);
    // R6
    a_r6_oam_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && oam_cell && !cfg_rdata[VPI_W]) |=> dec_code == 2'b00);
    // R5
    a_r5_oam_never_data: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && oam_cell) |=> dec_code != 2'b01);
endmodule

bind vpf_port_filter vpf_port_filter_chk #(
    .REG_W(REG_W), .VPI_W(VPI_W), .UNI_W(UNI_W), .VCI_W(VCI_W), .PTI_W(PTI_W)
) u_chk (.*);

// File: tb/vpf_port_filter_test.sv
module vpf_port_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        nni_mode = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [11:0] hdr_vpi = '0;
    logic [15:0] hdr_vci = '0;
    logic [2:0]  hdr_pti = '0;
    logic        dec_valid;
    logic [1:0]  dec_code;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_cfg = '0;

    always #5ns clk = ~clk;

    vpf_port_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .nni_mode(nni_mode), .hdr_valid(hdr_valid),
        .hdr_vpi(hdr_vpi), .hdr_vci(hdr_vci), .hdr_pti(hdr_pti),
        .dec_valid(dec_valid), .dec_code(dec_code)
    );

    function automatic logic [1:0] exp_dec(input logic [15:0] c, input logic nni,
                                           input logic [11:0] v, input logic [15:0] ci,
                                           input logic [2:0] p);
        logic hit, oam;
        hit = nni ? (v == c[11:0]) : (v[7:0] == c[7:0]);
        oam = (ci == 16'd3) || (ci == 16'd4) || (p == 3'b100) || (p == 3'b101);
        if (!hit) return 2'b00;
        if (oam) return c[12] ? 2'b10 : 2'b00;
        return 2'b01;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_cfg = v & 16'h1FFF;
        check("R2", cfg_rdata, m_cfg);
    endtask

    task automatic send(input string req, input logic nni, input logic [11:0] v,
                        input logic [15:0] ci, input logic [2:0] p);
        logic [1:0] e;
        @(negedge clk);
        nni_mode = nni; hdr_valid = 1'b1; hdr_vpi = v; hdr_vci = ci; hdr_pti = p;
        e = exp_dec(m_cfg, nni, v, ci, p);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R8", dec_valid, 1);
        check(req, dec_code, e);
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", cfg_rdata, 16'h0000);
        check("R1", dec_valid, 0);
        check("R1", dec_code, 2'b00);

        // R2 reserved bits read zero
        write_cfg(16'hFFFF);
        write_cfg(16'h0000);

        // R3 UNI: upper nibbles ignored on both sides
        write_cfg(16'h1A55);
        send("R3", 1'b0, 12'h355, 16'd40, 3'b000);
        send("R3", 1'b0, 12'hF55, 16'd40, 3'b010);
        send("R3", 1'b0, 12'hA56, 16'd40, 3'b000);
        // R4 NNI: full width
        send("R4", 1'b1, 12'h355, 16'd40, 3'b000);
        send("R4", 1'b1, 12'hA55, 16'd40, 3'b000);
        // R5 / R6 OAM forms with enable set
        send("R5", 1'b1, 12'hA55, 16'd3, 3'b000);
        send("R5", 1'b1, 12'hA55, 16'd4, 3'b000);
        send("R5", 1'b1, 12'hA55, 16'd9, 3'b100);
        send("R5", 1'b1, 12'hA55, 16'd9, 3'b101);
        send("R5", 1'b1, 12'hA55, 16'd9, 3'b110);
        send("R5", 1'b1, 12'hA55, 16'd5, 3'b000);
        // R7 mismatched OAM still dropped
        send("R7", 1'b1, 12'hA54, 16'd3, 3'b000);
        // R6 enable cleared
        write_cfg(16'h0A55);
        send("R6", 1'b1, 12'hA55, 16'd4, 3'b000);
        send("R6", 1'b0, 12'h055, 16'd9, 3'b101);
        send("R7", 1'b0, 12'h055, 16'd9, 3'b001);

        // R8 back-to-back strobes and idle afterwards
        @(negedge clk);
        nni_mode = 1'b1; hdr_valid = 1'b1; hdr_vpi = 12'hA55; hdr_vci = 16'd9; hdr_pti = 3'b000;
        @(negedge clk);
        hdr_vpi = 12'h123;
        check("R8", dec_valid, 1);
        check("R8", dec_code, 2'b01);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R8", dec_valid, 1);
        check("R8", dec_code, 2'b00);
        @(negedge clk);
        check("R8", dec_valid, 0);
        check("R8", dec_code, 2'b00);

        // R9 write in the strobe cycle affects later headers only
        @(negedge clk);
        nni_mode = 1'b1; hdr_valid = 1'b1; hdr_vpi = 12'hA55; hdr_vci = 16'd9; hdr_pti = 3'b000;
        cfg_wr = 1'b1; cfg_wdata = 16'h1123;
        @(negedge clk);
        hdr_valid = 1'b0; cfg_wr = 1'b0;
        m_cfg = 16'h1123;
        check("R9", dec_code, 2'b01);
        check("R9", cfg_rdata, 16'h1123);
        send("R9", 1'b1, 12'hA55, 16'd9, 3'b000);
        send("R9", 1'b1, 12'h123, 16'd9, 3'b000);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] v;
            logic [15:0] ci;
            logic [2:0]  p;
            logic        nni;
            if (i % 50 == 0) write_cfg(16'($urandom));
            nni = 1'($urandom);
            case ($urandom % 3)
                0: v = 12'($urandom);
                1: v = m_cfg[11:0];
                default: v = {4'($urandom), m_cfg[7:0]};
            endcase
            case ($urandom % 3)
                0: ci = 16'd3 + 16'($urandom % 2);
                default: ci = 16'($urandom);
            endcase
            p = 3'($urandom);
            send(nni ? "R4" : "R3", nni, v, ci, p);
        end

        @(negedge clk);
        check("R8", dec_valid, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule